// File: doc/BRIEF.md
# Display Link Power-Up Sequencer

This block is the transmitter-side controller of a low-swing serial display link. It runs on the fast link clock, which is six times the pixel clock. It brings the link clock line and the data lines from a fully undriven state into continuous streaming. The block waits until the power-down input is released and the PLL reports lock. It then plays a fixed training preamble that lets the receiver tune its current thresholds. After the preamble it starts toggling the clock line and passing serial data bits onto the data lines.

The preamble has three phases, each exactly `PHASE_LEN` link-clock cycles long:

1. The clock line is held Low. The data lines are left undriven.
2. The clock line is held High.
3. The clock line and every data line are held Low.

The receiver samples its calibration point on the Low-to-High edge between the first two phases. The whole sequence is gated by the enable condition. If power-down is asserted or PLL lock is lost at any point, every driver returns to off on the next cycle. In the off state no line current flows.

Top module: `link_pwrup_seq`

## Requirements
- R1: While reset is asserted, and after it is released, the block sits in phase code 0 (off). In that phase the clock and all data drives are 2'b00 (off) and `streaming` is 0. Drive codes are 2'b00 for off, 2'b01 for Low (high current) and 2'b10 for High (low current).
- R2: The sequence leaves off only at a clock edge where `pd_n` and `pll_locked` are both 1. From the next cycle, `phase` reads 1. Either input alone keeps the block in phase 0.
- R3: In phase 1, the clock drive is 2'b01 and the data drives are 2'b00. The phase lasts exactly 180 cycles.
- R4: In phase 2, the clock drive is 2'b10 and the data drives are 2'b00. The phase lasts exactly 180 cycles.
- R5: In phase 3, the clock drive and every data drive are 2'b01. The phase lasts exactly 180 cycles. After it, phase 4 (streaming) follows.
- R6: In phase 4, the clock drive repeats a six-cycle pattern: 2'b10 for three cycles, then 2'b01 for three cycles. It starts at 2'b10 in the first streaming cycle.
- R7: In phase 4, data line i (bits [2i+1:2i] of `data_drv`) is 2'b10 when `data_in[i]` is 1 and 2'b01 when it is 0. `streaming` is 1 exactly when `phase` is 4.
- R8: If `pd_n` or `pll_locked` is 0 at a clock edge, then from the next cycle `phase` is 0, all drives are 2'b00 and `streaming` is 0. This holds in any phase.
- R9: Phases only advance in order, 1 to 2 to 3 to 4. A new enable after a drop restarts at phase 1, again with the full 180-cycle length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock (six times the pixel clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Power-down release, active high |
| pll_locked | input | 1 | PLL lock indication |
| data_in | input | N_DATA | Serial bits for the data lines while streaming |
| clk_drv | output | 2 | Clock line drive code |
| data_drv | output | 2*N_DATA | Data line drive codes, line i at [2i+1:2i] |
| streaming | output | 1 | High while the link streams |
| phase | output | 3 | Phase code 0 to 4 |

## Verification
The assertions check the following on every cycle:
- the line levels that belong to each phase;
- that all drivers are off in phase 0;
- the one-cycle fall to off whenever the enable drops;
- the in-order phase advance;
- the exact dwell length of each training phase;
- that streaming begins with the clock High.

The bench scenarios are what show the rest:
- the full preamble timing, counted from a release of power-down;
- the three-High, three-Low clock pattern held over many pixel periods;
- data following `data_in`;
- that neither enable input alone starts the link;
- that a restart after a drop replays the full preamble length.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;

   typedef enum logic [1:0] {
      DRV_OFF  = 2'b00,
      DRV_LOW  = 2'b01,
      DRV_HIGH = 2'b10
   } drv_t;

   typedef enum logic [2:0] {
      PH_OFF    = 3'd0,
      PH_CAL_LO = 3'd1,
      PH_CAL_HI = 3'd2,
      PH_QUIET  = 3'd3,
      PH_STREAM = 3'd4
   } phase_t;

   function automatic drv_t bit_to_drv(input logic b);
      return b ? DRV_HIGH : DRV_LOW;
   endfunction

endpackage

// File: rtl/lps_phase_ctrl.sv
module lps_phase_ctrl
   import link_seq_pkg::*;
#(
   parameter int PHASE_LEN = 180
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   enable,
   output phase_t phase
);

   localparam int CNT_W = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_LEN - 1);

   phase_t           state_q, state_d;
   logic [CNT_W-1:0] cnt_q;
   logic             at_last;
   logic             training;

   assign at_last  = (cnt_q == LAST);
   assign training = (state_q == PH_CAL_LO) || (state_q == PH_CAL_HI) ||
                     (state_q == PH_QUIET);

   always_comb begin
      state_d = state_q;
      if (!enable) begin
         state_d = PH_OFF;
      end else begin
         unique case (state_q)
            PH_OFF:    state_d = PH_CAL_LO;
            PH_CAL_LO: if (at_last) state_d = PH_CAL_HI;
            PH_CAL_HI: if (at_last) state_d = PH_QUIET;
            PH_QUIET:  if (at_last) state_d = PH_STREAM;
            PH_STREAM: state_d = PH_STREAM;
            default:   state_d = PH_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_OFF;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_d != state_q || !training)
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign phase = state_q;

endmodule

// File: rtl/lps_clk_toggle.sv
module lps_clk_toggle #(
   parameter int DIV = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic level
);

   localparam int TW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam int HALF = DIV / 2;

   logic [TW-1:0] div_q;
   logic [TW-1:0] div_inc;

   generate
      if ((1 << TW) == DIV) begin : g_pow2
         assign div_inc = div_q + 1'b1;
      end else begin : g_modn
         assign div_inc = (div_q == TW'(DIV - 1)) ? '0 : div_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_q <= '0;
      else if (!active)
         div_q <= '0;
      else
         div_q <= div_inc;
   end

   assign level = (div_q < TW'(HALF));

endmodule

// File: rtl/lps_line_map.sv
module lps_line_map
   import link_seq_pkg::*;
#(
   parameter int N_DATA = 3
) (
   input  phase_t              phase,
   input  logic                clk_level,
   input  logic [N_DATA-1:0]   data_in,
   output logic [1:0]          clk_drv,
   output logic [2*N_DATA-1:0] data_drv
);

   always_comb begin
      unique case (phase)
         PH_CAL_LO: clk_drv = DRV_LOW;
         PH_CAL_HI: clk_drv = DRV_HIGH;
         PH_QUIET:  clk_drv = DRV_LOW;
         PH_STREAM: clk_drv = clk_level ? DRV_HIGH : DRV_LOW;
         default:   clk_drv = DRV_OFF;
      endcase
   end

   generate
      for (genvar i = 0; i < N_DATA; i++) begin : g_line
         always_comb begin
            unique case (phase)
               PH_QUIET:  data_drv[2*i +: 2] = DRV_LOW;
               PH_STREAM: data_drv[2*i +: 2] = bit_to_drv(data_in[i]);
               default:   data_drv[2*i +: 2] = DRV_OFF;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/link_pwrup_seq.sv
module link_pwrup_seq
   import link_seq_pkg::*;
#(
   parameter int N_DATA    = 3,
   parameter int PHASE_LEN = 180,
   parameter int DIV       = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pd_n,
   input  logic                pll_locked,
   input  logic [N_DATA-1:0]   data_in,
   output logic [1:0]          clk_drv,
   output logic [2*N_DATA-1:0] data_drv,
   output logic                streaming,
   output logic [2:0]          phase
);

   generate
      if (N_DATA < 1) begin : g_bad_lines
         $error("N_DATA must be at least 1");
      end
      if (PHASE_LEN < 2) begin : g_bad_len
         $error("PHASE_LEN must be at least 2");
      end
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("DIV must be an even value of at least 2");
      end
   endgenerate

   phase_t ph;
   logic   enable;
   logic   clk_level;

   assign enable = pd_n & pll_locked;

   lps_phase_ctrl #(
      .PHASE_LEN(PHASE_LEN)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .enable(enable),
      .phase (ph)
   );

   lps_clk_toggle #(
      .DIV(DIV)
   ) u_tog (
      .clk   (clk),
      .rst_n (rst_n),
      .active(ph == PH_STREAM),
      .level (clk_level)
   );

   lps_line_map #(
      .N_DATA(N_DATA)
   ) u_map (
      .phase    (ph),
      .clk_level(clk_level),
      .data_in  (data_in),
      .clk_drv  (clk_drv),
      .data_drv (data_drv)
   );

   assign streaming = (ph == PH_STREAM);
   assign phase     = ph;

endmodule

// File: rtl/lps_checker.sv
module lps_checker #(
   parameter int N_DATA    = 3,
   parameter int PHASE_LEN = 180
) (
   input logic                clk,
   input logic                rst_n,
   input logic                pd_n,
   input logic                pll_locked,
   input logic [N_DATA-1:0]   data_in,
   input logic [1:0]          clk_drv,
   input logic [2*N_DATA-1:0] data_drv,
   input logic                streaming,
   input logic [2:0]          phase
);

   logic [2:0]  last_ph;
   logic [15:0] dwell;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_ph <= 3'd0;
         dwell   <= '0;
      end else begin
         last_ph <= phase;
         if (phase != last_ph)
            dwell <= '0;
         else if (dwell != 16'hFFFF)
            dwell <= dwell + 1'b1;
      end
   end

   // R1
   off_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase == 3'd0 |-> (clk_drv == 2'b00 && data_drv == '0 && !streaming));

   // R3
   cal_lo_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase == 3'd1 |-> (clk_drv == 2'b01 && data_drv == '0));

   // R4
   cal_hi_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase == 3'd2 |-> (clk_drv == 2'b10 && data_drv == '0));

   // R5
   quiet_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase == 3'd3 |-> (clk_drv == 2'b01 && data_drv == {N_DATA{2'b01}}));

   // R5
   dwell_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != $past(phase) && phase != 3'd0 &&
       $past(phase) inside {3'd1, 3'd2, 3'd3}) |-> dwell == 16'(PHASE_LEN - 1));

   // R6
   stream_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd4 && $past(phase) != 3'd4) |-> clk_drv == 2'b10);

   // R7
   stream_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      streaming == (phase == 3'd4));

   // R8
   drop_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pd_n && pll_locked) |=> (phase == 3'd0 && clk_drv == 2'b00 && !streaming));

   // R9
   phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != $past(phase) && phase != 3'd0) |-> phase == $past(phase) + 3'd1);

endmodule

bind link_pwrup_seq lps_checker #(
   .N_DATA   (N_DATA),
   .PHASE_LEN(PHASE_LEN)
) u_lps_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .pd_n      (pd_n),
   .pll_locked(pll_locked),
   .data_in   (data_in),
   .clk_drv   (clk_drv),
   .data_drv  (data_drv),
   .streaming (streaming),
   .phase     (phase)
);

// File: tb/link_pwrup_seq_bench.sv
module link_pwrup_seq_bench;

   localparam int N_DATA = 3;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              pd_n;
   logic              pll_locked;
   logic [N_DATA-1:0] data_in;
   logic [1:0]        clk_drv;
   logic [5:0]        data_drv;
   logic              streaming;
   logic [2:0]        phase;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   link_pwrup_seq u_link_pwrup_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pd_n      (pd_n),
      .pll_locked(pll_locked),
      .data_in   (data_in),
      .clk_drv   (clk_drv),
      .data_drv  (data_drv),
      .streaming (streaming),
      .phase     (phase)
   );

   // {k[11:0], phase[2:0], clk_drv[1:0], data_drv[5:0]}, k = edges since enable
   // data_in = 3'b101 during the walk
   localparam int NV = 14;
   localparam logic [22:0] VEC [NV] = '{
      {12'd0,   3'd0, 2'b00, 6'b000000},  // R1
      {12'd1,   3'd1, 2'b01, 6'b000000},  // R2 R3
      {12'd90,  3'd1, 2'b01, 6'b000000},  // R3
      {12'd180, 3'd1, 2'b01, 6'b000000},  // R3
      {12'd181, 3'd2, 2'b10, 6'b000000},  // R4
      {12'd360, 3'd2, 2'b10, 6'b000000},  // R4
      {12'd361, 3'd3, 2'b01, 6'b010101},  // R5
      {12'd540, 3'd3, 2'b01, 6'b010101},  // R5
      {12'd541, 3'd4, 2'b10, 6'b100110},  // R6 R7
      {12'd542, 3'd4, 2'b10, 6'b100110},  // R6
      {12'd543, 3'd4, 2'b10, 6'b100110},  // R6
      {12'd544, 3'd4, 2'b01, 6'b100110},  // R6
      {12'd546, 3'd4, 2'b01, 6'b100110},  // R6
      {12'd547, 3'd4, 2'b10, 6'b100110}   // R6
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_state(input string req, input logic [2:0] ph,
                            input logic [1:0] ck, input logic [5:0] dt);
      chk(req, "phase", 32'(phase), 32'(ph));
      chk(req, "clk_drv", 32'(clk_drv), 32'(ck));
      chk(req, "data_drv", 32'(data_drv), 32'(dt));
      chk(req, "streaming", 32'(streaming), 32'(ph == 3'd4));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int idx;
      int highs;
      rst_n = 1'b0; pd_n = 1'b0; pll_locked = 1'b0; data_in = '0;
      repeat (3) @(negedge clk);
      chk_state("R1 in reset", 3'd0, 2'b00, 6'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_state("R1 after reset", 3'd0, 2'b00, 6'b0);

      // R2: each enable alone keeps the block off
      pd_n = 1'b1;
      repeat (10) @(negedge clk);
      chk_state("R2 pd_n only", 3'd0, 2'b00, 6'b0);
      pd_n = 1'b0; pll_locked = 1'b1;
      repeat (10) @(negedge clk);
      chk_state("R2 lock only", 3'd0, 2'b00, 6'b0);

      // table walk through the full preamble into streaming
      data_in = 3'b101;
      pd_n    = 1'b1;
      idx     = 0;
      for (int k = 0; k <= 547; k++) begin
         if (k > 0) @(negedge clk);
         if (idx < NV && int'(VEC[idx][22:11]) == k) begin
            chk_state($sformatf("table k=%0d", k), VEC[idx][10:8],
                      VEC[idx][7:6], VEC[idx][5:0]);
            idx++;
         end
      end

      // R7: data follows data_in while streaming
      data_in = 3'b010;
      #1;
      chk("R7", "data_drv", 32'(data_drv), 32'(6'b011001));

      // R6: three High out of every six cycles over ten pixel periods
      highs = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (clk_drv == 2'b10) highs++;
      end
      chk("R6", "high count", 32'(highs), 32'd30);

      // R8: losing lock while streaming
      pll_locked = 1'b0;
      @(negedge clk);
      chk_state("R8 lock drop", 3'd0, 2'b00, 6'b0);

      // R9: restart replays the full preamble length
      pll_locked = 1'b1;
      for (int k = 1; k <= 200; k++) begin
         @(negedge clk);
         if (k == 180) chk_state("R9 restart k=180", 3'd1, 2'b01, 6'b0);
         if (k == 181) chk_state("R9 restart k=181", 3'd2, 2'b10, 6'b0);
      end

      // R8: power-down during phase 2
      pd_n = 1'b0;
      @(negedge clk);
      chk_state("R8 pd drop", 3'd0, 2'b00, 6'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule